// File: doc/BRIEF.md
# Event Notification Routing Sequencer

This block takes one routing trigger at a time, made of a block number, a descriptor index and 31 bits of event data, and walks it through the delivery sequence. It fetches the event descriptor over a request/response table port. When queueing is enabled it stores a generation-tagged entry into a circular queue in memory. It then applies notification coalescing and asks a presenter to deliver the event to a target processor. When delivery fails it can leave a pending-priority mark in that processor's record. Finally it may escalate by re-running the whole sequence on a second descriptor.

Descriptor storage, processor records, queue memory and the presenter all sit outside the block. Each is reached through a port whose response may arrive in the same cycle as the request or any later cycle. The descriptor's mutable state word (queue index, generation, flip flag and two PQ pairs) is written back through the same table port. A trigger ends with a one-cycle `done` pulse carrying an outcome code: 0 complete, 1 bad descriptor, 2 bad processor record, 3 masked, 4 coalesced, 5 configuration error, 6 chained escalation.

Top module: `evt_route_seq`

## Requirements
- R1: A trigger whose descriptor lookup misses, or whose descriptor has flag bit 0 (valid) clear, ends with code 1 and makes no queue write and no presenter request.
- R2: With flag bit 1 (enqueue) set, one 32-bit word is written at queue base + index*4. Its bit 31 is the state-word generation bit (bit 4) and its bits 30:0 are the event data.
- R3: The queue holds 2^(size+10) entries. After a write, the index (state bits above 5) advances modulo that count. On a wrap to 0 the generation bit toggles, and the flip flag (state bit 5) takes the new generation value. Otherwise the flip flag is unchanged.
- R4: With flag bit 6 (silent) set, the notify stage is skipped: no PQ update, no presenter request, and processing goes straight to escalation.
- R5: With flag bit 7 (format) clear and priority 0xFF the trigger ends with code 3 after any enqueue. With format 1, priority 0xFF is not a mask.
- R6: With flag bit 2 (always notify) clear, the notify PQ pair (state bits 1:0, P high) steps 00->10 and notifies. It steps 10->11, keeps 11 and keeps 01, and these three do not notify. The state word is written back only if the pair changed. A non-notifying step ends the trigger with code 4.
- R7: A processor record that misses ends the trigger with code 2 and no presenter request.
- R8: A found reply ends the trigger with code 0. A not-found reply with flag bit 3 (backlog) set and format 0 ORs bit (7-p) into the record's pending byte for priority p of 0 to 7. Priorities above 7 add no bit.
- R9: A not-found reply with backlog set and format 1 ends with code 5 and leaves the record unchanged.
- R10: With flag bit 4 (escalate) set, the escalate PQ pair (state bits 3:2) steps as in R6 unless flag bit 5 (unconditional) is set. A notifying or unconditional escalation re-runs the sequence on the descriptor's escalation block, index and data. Escalate clear ends with code 0.
- R11: A descriptor reached by escalation that itself has escalate set ends the trigger with code 6 and no further re-run.
- R12: `done` is a one-cycle pulse that carries the code. A trigger offered while `busy` is high is ignored. At most one external request is active per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger offered (accepted when idle) |
| trig_blk | input | BLK_W | Descriptor block |
| trig_idx | input | IDX_W | Descriptor index |
| trig_data | input | 31 | Event data |
| busy | output | 1 | A trigger is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | Outcome code |
| desc_req | output | 1 | Descriptor read request |
| desc_blk | output | BLK_W | Descriptor block for read and write-back |
| desc_idx | output | IDX_W | Descriptor index for read and write-back |
| desc_rsp_valid | input | 1 | Descriptor response |
| desc_hit | input | 1 | Descriptor exists |
| desc_flags | input | 8 | Flag byte |
| desc_prio | input | 8 | Priority |
| desc_qsize | input | 4 | Queue size code |
| desc_qbase | input | ADDR_W | Queue base address |
| desc_tgt_blk | input | BLK_W | Target processor block |
| desc_tgt_idx | input | PIDX_W | Target processor index |
| desc_esc_blk | input | BLK_W | Escalation block |
| desc_esc_idx | input | IDX_W | Escalation index |
| desc_esc_data | input | 31 | Escalation data |
| desc_state | input | QIDX_W+6 | Mutable state word |
| desc_st_we | output | 1 | State word write-back strobe |
| desc_st_wdata | output | QIDX_W+6 | State word written back |
| mem_we | output | 1 | Queue write request |
| mem_addr | output | ADDR_W | Queue write address |
| mem_wdata | output | 32 | Queue entry |
| mem_ack | input | 1 | Queue write accepted |
| proc_req | output | 1 | Processor record read request |
| proc_blk | output | BLK_W | Processor block |
| proc_idx | output | PIDX_W | Processor index |
| proc_rsp_valid | input | 1 | Processor record response |
| proc_hit | input | 1 | Record exists and is valid |
| proc_ipb | input | 8 | Pending-priority byte |
| proc_we | output | 1 | Pending byte write strobe |
| proc_ipb_wdata | output | 8 | Updated pending byte |
| pres_req | output | 1 | Presenter request |
| pres_fmt | output | 1 | Format bit |
| pres_prio | output | 8 | Priority |
| pres_blk | output | BLK_W | Target processor block |
| pres_idx | output | PIDX_W | Target processor index |
| pres_rsp_valid | input | 1 | Presenter reply |
| pres_found | input | 1 | Target was found |

## Verification
The bench builds the block with an 11-bit queue index and 2-bit block and index fields, so queue size codes 0 and 1 fit completely. A full 1024-entry lap, and the wrap from the last slot at both sizes, take only a few thousand cycles. With four descriptors and four processor records, every PQ pair value can be swept on both the notify and escalate stages. The same small tables cover every priority from 0 to 9 in the pending-byte mapping and every route into and out of escalation, including the second-level chain fault.

// File: rtl/evt_route_seq.sv
module evt_route_seq #(
  parameter int BLK_W  = 4,
  parameter int IDX_W  = 12,
  parameter int PIDX_W = 16,
  parameter int QIDX_W = 20,
  parameter int ADDR_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_valid,
  input  logic [BLK_W-1:0]     trig_blk,
  input  logic [IDX_W-1:0]     trig_idx,
  input  logic [30:0]          trig_data,
  output logic                 busy,
  output logic                 done,
  output logic [2:0]           done_code,
  output logic                 desc_req,
  output logic [BLK_W-1:0]     desc_blk,
  output logic [IDX_W-1:0]     desc_idx,
  input  logic                 desc_rsp_valid,
  input  logic                 desc_hit,
  input  logic [7:0]           desc_flags,
  input  logic [7:0]           desc_prio,
  input  logic [3:0]           desc_qsize,
  input  logic [ADDR_W-1:0]    desc_qbase,
  input  logic [BLK_W-1:0]     desc_tgt_blk,
  input  logic [PIDX_W-1:0]    desc_tgt_idx,
  input  logic [BLK_W-1:0]     desc_esc_blk,
  input  logic [IDX_W-1:0]     desc_esc_idx,
  input  logic [30:0]          desc_esc_data,
  input  logic [QIDX_W+5:0]    desc_state,
  output logic                 desc_st_we,
  output logic [QIDX_W+5:0]    desc_st_wdata,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  output logic                 proc_req,
  output logic [BLK_W-1:0]     proc_blk,
  output logic [PIDX_W-1:0]    proc_idx,
  input  logic                 proc_rsp_valid,
  input  logic                 proc_hit,
  input  logic [7:0]           proc_ipb,
  output logic                 proc_we,
  output logic [7:0]           proc_ipb_wdata,
  output logic                 pres_req,
  output logic                 pres_fmt,
  output logic [7:0]           pres_prio,
  output logic [BLK_W-1:0]     pres_blk,
  output logic [PIDX_W-1:0]    pres_idx,
  input  logic                 pres_rsp_valid,
  input  logic                 pres_found
);

  localparam int ST_W = QIDX_W + 6;

  localparam logic [2:0] C_OK      = 3'd0;
  localparam logic [2:0] C_BADDESC = 3'd1;
  localparam logic [2:0] C_BADPROC = 3'd2;
  localparam logic [2:0] C_MASKED  = 3'd3;
  localparam logic [2:0] C_COAL    = 3'd4;
  localparam logic [2:0] C_CFGERR  = 3'd5;
  localparam logic [2:0] C_CHAIN   = 3'd6;

  localparam int F_VALID = 0, F_ENQ = 1, F_ALWAYS = 2, F_BACKLOG = 3;
  localparam int F_ESC = 4, F_UNCOND = 5, F_SILENT = 6, F_FMT = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_ENQ, S_NOTE, S_PROC, S_PRES, S_BLOG, S_ESC
  } state_e;

  state_e              state;
  logic                done_r;
  logic [2:0]          code_r;
  logic                depth_r;
  logic [BLK_W-1:0]    cur_blk;
  logic [IDX_W-1:0]    cur_idx;
  logic [30:0]         cur_data;
  logic [7:0]          flags_r;
  logic [7:0]          prio_r;
  logic [3:0]          qsize_r;
  logic [ADDR_W-1:0]   qbase_r;
  logic [BLK_W-1:0]    tgt_blk_r;
  logic [PIDX_W-1:0]   tgt_idx_r;
  logic [BLK_W-1:0]    esc_blk_r;
  logic [IDX_W-1:0]    esc_idx_r;
  logic [30:0]         esc_data_r;
  logic [ST_W-1:0]     st_r;
  logic [7:0]          ipb_r;

  logic [ST_W-1:0]     st_nxt;
  logic                st_we;
  logic [QIDX_W-1:0]   qmask;
  logic [QIDX_W-1:0]   qidx;
  logic [QIDX_W-1:0]   idx_inc;
  logic                wrap;
  logic [2:0]          n_step;
  logic [2:0]          e_step;
  logic                masked;
  logic [7:0]          ipb_bit;

  function automatic logic [2:0] pq_step(input logic [1:0] pq);
    case (pq)
      2'b00:   return 3'b110;
      2'b10:   return 3'b011;
      default: return {1'b0, pq};
    endcase
  endfunction

  assign qidx    = st_r[ST_W-1:6];
  assign idx_inc = (qidx + 1'b1) & qmask;
  assign wrap    = (idx_inc == '0);
  assign n_step  = pq_step(st_r[1:0]);
  assign e_step  = pq_step(st_r[3:2]);
  assign masked  = !flags_r[F_FMT] && (prio_r == 8'hFF);
  assign ipb_bit = (prio_r < 8'd8) ? (8'h80 >> prio_r[2:0]) : 8'h00;

  always_comb begin
    for (int i = 0; i < QIDX_W; i++) qmask[i] = (i < (int'(qsize_r) + 10));
  end

  always_comb begin
    st_nxt = st_r;
    st_we  = 1'b0;
    case (state)
      S_ENQ: if (mem_ack) begin
        st_nxt[ST_W-1:6] = idx_inc;
        st_nxt[4]        = wrap ? ~st_r[4] : st_r[4];
        st_nxt[5]        = wrap ? ~st_r[4] : st_r[5];
        st_we            = 1'b1;
      end
      S_NOTE: if (!flags_r[F_SILENT] && !masked && !flags_r[F_ALWAYS]) begin
        st_nxt[1:0] = n_step[1:0];
        st_we       = (n_step[1:0] != st_r[1:0]);
      end
      S_ESC: if (flags_r[F_ESC] && !depth_r && !flags_r[F_UNCOND]) begin
        st_nxt[3:2] = e_step[1:0];
        st_we       = (e_step[1:0] != st_r[3:2]);
      end
      default: ;
    endcase
  end

  assign busy           = (state != S_IDLE);
  assign done           = done_r;
  assign done_code      = code_r;
  assign desc_req       = (state == S_DREQ);
  assign desc_blk       = cur_blk;
  assign desc_idx       = cur_idx;
  assign desc_st_we     = st_we;
  assign desc_st_wdata  = st_nxt;
  assign mem_we         = (state == S_ENQ);
  assign mem_addr       = qbase_r + (ADDR_W'(qidx) << 2);
  assign mem_wdata      = {st_r[4], cur_data};
  assign proc_req       = (state == S_PROC);
  assign proc_blk       = tgt_blk_r;
  assign proc_idx       = tgt_idx_r;
  assign proc_we        = (state == S_BLOG);
  assign proc_ipb_wdata = ipb_r | ipb_bit;
  assign pres_req       = (state == S_PRES);
  assign pres_fmt       = flags_r[F_FMT];
  assign pres_prio      = prio_r;
  assign pres_blk       = tgt_blk_r;
  assign pres_idx       = tgt_idx_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      done_r     <= 1'b0;
      code_r     <= C_OK;
      depth_r    <= 1'b0;
      cur_blk    <= '0;
      cur_idx    <= '0;
      cur_data   <= '0;
      flags_r    <= '0;
      prio_r     <= '0;
      qsize_r    <= '0;
      qbase_r    <= '0;
      tgt_blk_r  <= '0;
      tgt_idx_r  <= '0;
      esc_blk_r  <= '0;
      esc_idx_r  <= '0;
      esc_data_r <= '0;
      st_r       <= '0;
      ipb_r      <= '0;
    end else begin
      done_r <= 1'b0;
      if (st_we) st_r <= st_nxt;
      case (state)
        S_IDLE: if (trig_valid) begin
          cur_blk  <= trig_blk;
          cur_idx  <= trig_idx;
          cur_data <= trig_data;
          depth_r  <= 1'b0;
          state    <= S_DREQ;
        end
        S_DREQ: if (desc_rsp_valid) begin
          if (!desc_hit || !desc_flags[F_VALID]) begin
            done_r <= 1'b1; code_r <= C_BADDESC; state <= S_IDLE;
          end else begin
            flags_r    <= desc_flags;
            prio_r     <= desc_prio;
            qsize_r    <= desc_qsize;
            qbase_r    <= desc_qbase;
            tgt_blk_r  <= desc_tgt_blk;
            tgt_idx_r  <= desc_tgt_idx;
            esc_blk_r  <= desc_esc_blk;
            esc_idx_r  <= desc_esc_idx;
            esc_data_r <= desc_esc_data;
            st_r       <= desc_state;
            state      <= desc_flags[F_ENQ] ? S_ENQ : S_NOTE;
          end
        end
        S_ENQ: if (mem_ack) state <= S_NOTE;
        S_NOTE: begin
          if (flags_r[F_SILENT]) state <= S_ESC;
          else if (masked) begin
            done_r <= 1'b1; code_r <= C_MASKED; state <= S_IDLE;
          end else if (!flags_r[F_ALWAYS] && !n_step[2]) begin
            done_r <= 1'b1; code_r <= C_COAL; state <= S_IDLE;
          end else state <= S_PROC;
        end
        S_PROC: if (proc_rsp_valid) begin
          if (!proc_hit) begin
            done_r <= 1'b1; code_r <= C_BADPROC; state <= S_IDLE;
          end else begin
            ipb_r <= proc_ipb;
            state <= S_PRES;
          end
        end
        S_PRES: if (pres_rsp_valid) begin
          if (pres_found) begin
            done_r <= 1'b1; code_r <= C_OK; state <= S_IDLE;
          end else if (flags_r[F_BACKLOG]) begin
            if (flags_r[F_FMT]) begin
              done_r <= 1'b1; code_r <= C_CFGERR; state <= S_IDLE;
            end else state <= S_BLOG;
          end else state <= S_ESC;
        end
        S_BLOG: state <= S_ESC;
        S_ESC: begin
          if (!flags_r[F_ESC]) begin
            done_r <= 1'b1; code_r <= C_OK; state <= S_IDLE;
          end else if (depth_r) begin
            done_r <= 1'b1; code_r <= C_CHAIN; state <= S_IDLE;
          end else if (!flags_r[F_UNCOND] && !e_step[2]) begin
            done_r <= 1'b1; code_r <= C_COAL; state <= S_IDLE;
          end else begin
            cur_blk  <= esc_blk_r;
            cur_idx  <= esc_idx_r;
            cur_data <= esc_data_r;
            depth_r  <= 1'b1;
            state    <= S_DREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_req, mem_we, proc_req, pres_req, proc_we}));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pres_req |-> !(!pres_fmt && pres_prio == 8'hFF));

  assert_silent_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pres_req |-> !flags_r[F_SILENT]);

  assert_backlog_fmt0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_we |-> !pres_fmt);

  assert_chain_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ESC && depth_r && flags_r[F_ESC]) |=> (done && done_code == C_CHAIN));

  assert_wrap_gen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && desc_st_we && desc_st_wdata[ST_W-1:6] == '0) |->
      (desc_st_wdata[4] != mem_wdata[31] && desc_st_wdata[5] == desc_st_wdata[4]));

endmodule

// File: tb/test_evt_route_seq.sv
module test_evt_route_seq;
  localparam int BW = 2, IW = 2, PW = 2, QW = 11, AW = 32, SW = QW + 6;
  localparam logic [7:0] FV = 8'h01, FE = 8'h02, FA = 8'h04, FB = 8'h08;
  localparam logic [7:0] FX = 8'h10, FU = 8'h20, FS = 8'h40, F1 = 8'h80;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic trig_valid = 0;
  logic [BW-1:0] trig_blk = 0;
  logic [IW-1:0] trig_idx = 0;
  logic [30:0] trig_data = 0;
  logic busy, done, desc_req, desc_st_we, mem_we, proc_req, proc_we, pres_req, pres_fmt;
  logic [2:0] done_code;
  logic [BW-1:0] desc_blk, proc_blk, pres_blk;
  logic [IW-1:0] desc_idx;
  logic [PW-1:0] proc_idx, pres_idx;
  logic [SW-1:0] desc_st_wdata;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [7:0] proc_ipb_wdata, pres_prio;

  logic          d_hit [4];
  logic [7:0]    d_flags [4];
  logic [7:0]    d_prio [4];
  logic [3:0]    d_qsize [4];
  logic [AW-1:0] d_qbase [4];
  logic [PW-1:0] d_tgt [4];
  logic [BW-1:0] d_eblk [4];
  logic [IW-1:0] d_eidx [4];
  logic [30:0]   d_edata [4];
  logic [SW-1:0] d_state [4];
  logic          p_hit [4];
  logic [7:0]    p_ipb [4];
  logic          found = 0;

  int checks = 0, fails = 0;
  int st_cnt, mem_cnt, pres_cnt;
  logic [AW-1:0] last_addr;
  logic [31:0] last_data;
  logic [BW-1:0] st_blk;
  logic [7:0] last_prio;

  evt_route_seq #(.BLK_W(BW), .IDX_W(IW), .PIDX_W(PW), .QIDX_W(QW), .ADDR_W(AW)) i_evt_route_seq (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_blk(trig_blk), .trig_idx(trig_idx),
    .trig_data(trig_data), .busy(busy), .done(done), .done_code(done_code),
    .desc_req(desc_req), .desc_blk(desc_blk), .desc_idx(desc_idx), .desc_rsp_valid(desc_req),
    .desc_hit(d_hit[desc_idx]), .desc_flags(d_flags[desc_idx]), .desc_prio(d_prio[desc_idx]),
    .desc_qsize(d_qsize[desc_idx]), .desc_qbase(d_qbase[desc_idx]), .desc_tgt_blk(2'd1),
    .desc_tgt_idx(d_tgt[desc_idx]), .desc_esc_blk(d_eblk[desc_idx]), .desc_esc_idx(d_eidx[desc_idx]),
    .desc_esc_data(d_edata[desc_idx]), .desc_state(d_state[desc_idx]),
    .desc_st_we(desc_st_we), .desc_st_wdata(desc_st_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_we),
    .proc_req(proc_req), .proc_blk(proc_blk), .proc_idx(proc_idx), .proc_rsp_valid(proc_req),
    .proc_hit(p_hit[proc_idx]), .proc_ipb(p_ipb[proc_idx]), .proc_we(proc_we),
    .proc_ipb_wdata(proc_ipb_wdata), .pres_req(pres_req), .pres_fmt(pres_fmt),
    .pres_prio(pres_prio), .pres_blk(pres_blk), .pres_idx(pres_idx),
    .pres_rsp_valid(pres_req), .pres_found(found));

  always @(posedge clk) begin
    if (desc_st_we) begin d_state[desc_idx] <= desc_st_wdata; st_cnt <= st_cnt + 1; st_blk <= desc_blk; end
    if (mem_we) begin mem_cnt <= mem_cnt + 1; last_addr <= mem_addr; last_data <= mem_wdata; end
    if (proc_we) p_ipb[proc_idx] <= proc_ipb_wdata;
    if (pres_req) begin pres_cnt <= pres_cnt + 1; last_prio <= pres_prio; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setd(input int i, input logic [7:0] fl, input logic [7:0] pr,
                      input logic [3:0] qs, input logic [SW-1:0] st);
    d_hit[i] = 1; d_flags[i] = fl; d_prio[i] = pr; d_qsize[i] = qs;
    d_qbase[i] = 32'h1000 * (i + 1); d_tgt[i] = 2'(i); d_state[i] = st;
    d_eblk[i] = 0; d_eidx[i] = 0; d_edata[i] = 0;
  endtask

  task automatic run(input int i, input logic [30:0] data);
    @(negedge clk);
    st_cnt = 0; mem_cnt = 0; pres_cnt = 0;
    trig_valid = 1; trig_idx = 2'(i); trig_blk = 2'(i); trig_data = data;
    @(negedge clk);
    trig_valid = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin setd(i, 0, 0, 0, 0); p_hit[i] = 1; p_ipb[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset done", done, 0);
    chk("R12 reset requests", {desc_req, mem_we, proc_req, pres_req, proc_we}, 0);
    rst_n = 1;

    // R1
    d_hit[0] = 0; d_flags[0] = FV | FE | FA;
    run(0, 31'h5);
    chk("R1 miss code", done_code, 1);
    chk("R1 miss no write", mem_cnt + pres_cnt, 0);
    setd(0, FE | FA, 8'h01, 0, 0);
    run(0, 31'h5);
    chk("R1 invalid code", done_code, 1);
    chk("R1 invalid no write", mem_cnt + pres_cnt, 0);

    // R2 R3 R5: enqueue sweep over size, start index and generation; masked afterwards
    for (int qs = 0; qs < 2; qs++) begin
      for (int k = 0; k < 3; k++) begin
        for (int g = 0; g < 2; g++) begin
          int n, i0, ni;
          logic ng, nf;
          n = 1 << (qs + 10);
          i0 = (k == 0) ? 0 : (k == 1) ? 5 + qs * 700 : n - 1;
          ni = (i0 + 1) % n;
          ng = (ni == 0) ? !g[0] : g[0];
          nf = (ni == 0) ? !g[0] : 1'b0;
          setd(1, FV | FE | FA, 8'hFF, 4'(qs), {11'(i0), 1'b0, g[0], 4'b0110});
          run(1, 31'h2ABC_0000 + 31'(i0));
          chk("R2 address", last_addr, 32'h2000 + 32'(i0 * 4));
          chk("R2 entry", last_data, {g[0], 31'h2ABC_0000 + 31'(i0)});
          chk("R3 state", d_state[1], {11'(ni), nf, ng, 4'b0110});
          chk("R5 masked code", done_code, 3);
          chk("R5 masked no presenter", pres_cnt, 0);
        end
      end
    end
    // R3: a full lap of 1024 entries
    setd(1, FV | FE | FA, 8'hFF, 0, 0);
    for (int t = 0; t < 1024; t++) run(1, 31'(t));
    chk("R3 lap state", d_state[1], {11'd0, 1'b1, 1'b1, 4'b0});
    chk("R3 lap last addr", last_addr, 32'h2000 + 32'd4092);

    // R6: notify PQ sweep
    found = 1;
    for (int pq = 0; pq < 4; pq++) begin
      logic [1:0] npq;
      npq = (pq == 0) ? 2'b10 : (pq == 2) ? 2'b11 : 2'(pq);
      setd(2, FV, 8'd3, 0, {11'd0, 2'b00, 2'b01, 2'(pq)});
      run(2, 31'h1);
      chk("R6 pq result", d_state[2][3:0], {2'b01, npq});
      chk("R6 writeback count", st_cnt, (npq != 2'(pq)) ? 1 : 0);
      chk("R6 code", done_code, (pq == 0) ? 0 : 4);
      chk("R6 presenter", pres_cnt, (pq == 0) ? 1 : 0);
    end

    // R7
    setd(2, FV | FA, 8'd3, 0, 0); p_hit[2] = 0;
    run(2, 31'h1);
    chk("R7 code", done_code, 2);
    chk("R7 no presenter", pres_cnt, 0);
    p_hit[2] = 1;

    // R8: backlog priority sweep
    found = 0;
    for (int p = 0; p < 10; p++) begin
      setd(3, FV | FA | FB, 8'(p), 0, 0); p_ipb[3] = 8'h00;
      run(3, 31'h7);
      chk("R8 pending byte", p_ipb[3], (p < 8) ? (8'h01 << (7 - p)) : 8'h00);
      chk("R8 code", done_code, 0);
    end
    setd(3, FV | FA | FB, 8'd6, 0, 0); p_ipb[3] = 8'h05;
    run(3, 31'h7);
    chk("R8 pending or", p_ipb[3], 8'h07);
    found = 1; p_ipb[3] = 8'h05;
    setd(3, FV | FA | FB, 8'd0, 0, 0);
    run(3, 31'h7);
    chk("R8 found untouched", p_ipb[3], 8'h05);
    chk("R8 found code", done_code, 0);

    // R9 and R5 format 1 corner
    found = 0; p_ipb[3] = 8'h00;
    setd(3, FV | FA | FB | F1, 8'hFF, 0, 0);
    run(3, 31'h7);
    chk("R9 code", done_code, 5);
    chk("R9 record untouched", p_ipb[3], 8'h00);
    chk("R5 format1 not masked", pres_cnt, 1);

    // R4 R10: silent unconditional escalation
    setd(0, FV | FS | FX | FU, 8'd2, 0, 0);
    d_eblk[0] = 2'd2; d_eidx[0] = 2'd1; d_edata[0] = 31'h0123_4567;
    setd(1, FV | FE | FA, 8'hFF, 0, {11'd9, 1'b0, 1'b1, 4'b0});
    run(0, 31'h55);
    chk("R4 no presenter", pres_cnt, 0);
    chk("R4 escalated code", done_code, 3);
    chk("R10 escalated entry", last_data, {1'b1, 31'h0123_4567});
    chk("R10 escalated addr", last_addr, 32'h2000 + 32'd36);
    chk("R10 escalated block", st_blk, 2'd2);
    chk("R4 no notify pq change", d_state[0][1:0], 2'b00);

    // R10: escalate PQ sweep
    for (int pq = 0; pq < 4; pq++) begin
      logic [1:0] epq;
      epq = (pq == 0) ? 2'b10 : (pq == 2) ? 2'b11 : 2'(pq);
      setd(0, FV | FS | FX, 8'd2, 0, {11'd0, 2'b00, 2'(pq), 2'b00});
      d_eidx[0] = 2'd1;
      setd(1, FV | FA, 8'hFF, 0, 0);
      run(0, 31'h55);
      chk("R10 esc pq", d_state[0][3:0], {epq, 2'b00});
      chk("R10 esc code", done_code, (pq == 0) ? 3 : 4);
    end
    // R10: not found without backlog escalates; escalate clear ends complete
    setd(0, FV | FA | FX | FU, 8'd2, 0, 0); d_eidx[0] = 2'd1;
    setd(1, FV | FA, 8'hFF, 0, 0);
    run(0, 31'h55);
    chk("R10 after notify code", done_code, 3);
    chk("R10 after notify presenter", pres_cnt, 1);
    setd(0, FV | FA, 8'd2, 0, 0);
    run(0, 31'h55);
    chk("R10 no escalate code", done_code, 0);

    // R11
    setd(0, FV | FS | FX | FU, 8'd2, 0, 0); d_eidx[0] = 2'd1;
    setd(1, FV | FS | FX | FU, 8'd2, 0, 0); d_eidx[1] = 2'd0;
    run(0, 31'h55);
    chk("R11 chain code", done_code, 6);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);

    // R12: triggers while busy are ignored
    setd(1, FV | FE | FA, 8'hFF, 0, 0);
    setd(2, FV | FE | FA, 8'hFF, 0, 0);
    @(negedge clk);
    mem_cnt = 0;
    trig_valid = 1; trig_idx = 2'd1;
    @(negedge clk); trig_idx = 2'd2;
    @(negedge clk);
    @(negedge clk); trig_valid = 0;
    repeat (10) @(negedge clk);
    chk("R12 busy trigger ignored", mem_cnt, 1);
    chk("R12 other descriptor untouched", d_state[2], 0);
    chk("R12 idle after", busy, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule